// File: doc/BRIEF.md
# Byte-Pair IDE Data Bridge

This block joins an 8-bit ISA IO bus to the 16-bit data register of an IDE drive. Software moves each 16-bit drive word as two byte accesses in a row. A single holding byte and a phase flag join the two bytes into one drive word. The block also passes accesses to the other task-file registers straight through as 8-bit cycles on the low byte lane.

The direction of a data transfer is taken from address bit 4 and never from the strobes. Reads of the data register use window offset 00h and writes use offset 10h. Because the direction is known before the strobe arrives, a read can reach the drive on the first byte and a write can reach it on the second byte, and one latch serves both directions.

The host strobes `bus_rd` and `bus_wr` are active high and each is high for one clock per access. The outputs follow the inputs combinationally within that cycle. The phase flag and the holding byte update on the clock edge that ends the access.

Top module: `ide_byte_bridge`

## Requirements
- R1: After reset the phase flag is 0, so the first data access acts as the first byte of a pair. With no strobe asserted, `ide_rd`, `ide_wr` and `bus_rdata` are 0.
- R2: Only `bus_addr[9:5]` equal to `BASE[9:5]` selects the block. Any access outside that 32-port window asserts no drive strobe, returns 0 and leaves the phase and the holding byte unchanged.
- R3: A read at window offset 00h with phase 0 asserts `ide_rd` with `ide_reg`=0 and returns `ide_rdata[7:0]` on `bus_rdata`. It also captures `ide_rdata[15:8]` in the holding byte.
- R4: A read at offset 00h with phase 1 returns the held high byte without asserting `ide_rd`.
- R5: A write at offset 10h with phase 0 asserts no drive strobe and stores `bus_wdata` as the low byte.
- R6: A write at offset 10h with phase 1 asserts `ide_wr` with `ide_reg`=0 and `ide_wdata` = {`bus_wdata`, stored low byte}.
- R7: Address bit 4 alone sets the direction. A write strobe at offset 00h and a read strobe at offset 10h have no effect: there is no drive strobe, the read returns 0, and the phase does not change.
- R8: Every data access at offsets 00h or 10h toggles the phase. An access to offsets 01h–07h clears the phase to 0.
- R9: Window offsets 01h–07h pass through as 8-bit cycles with `ide_reg` = `bus_addr[2:0]`. A read asserts `ide_rd` and returns `ide_rdata[7:0]`. A write asserts `ide_wr` with `ide_wdata` = {8'h00, `bus_wdata`}. Offsets 08h–0Fh and 11h–1Fh have no effect.
- R10: A cycle with `bus_rd` and `bus_wr` both high is ignored: there is no drive strobe and no state change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 10 | ISA IO address (A0..A9) |
| bus_rd | input | 1 | Host IO read strobe, active high |
| bus_wr | input | 1 | Host IO write strobe, active high |
| bus_wdata | input | 8 | Host write byte |
| bus_rdata | output | 8 | Byte returned to the host |
| ide_reg | output | 3 | Drive register index |
| ide_rd | output | 1 | Drive read strobe |
| ide_wr | output | 1 | Drive write strobe |
| ide_wdata | output | 16 | Drive write word |
| ide_rdata | input | 16 | Drive read word |

## Verification
The bench runs mixed read/write sequences. A design that mishandles the shared latch would hand back a stale write byte as the high byte of a read, or would write a read's high byte to the drive. A register access between the two bytes of a pair must restart the pairing. A design that fails to clear the phase would skip the drive strobe on the next read. Strobes with the wrong direction at offsets 00h and 10h must leave the phase alone, or all later pairs would shift by one byte. Addresses that match only in the low five bits, and cycles with both strobes high, must stay invisible to the drive.

// File: rtl/ide_byte_bridge.sv
module ide_byte_bridge #(
  parameter logic [9:0] BASE = 10'h300
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [9:0]  bus_addr,
  input  logic        bus_rd,
  input  logic        bus_wr,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  output logic [2:0]  ide_reg,
  output logic        ide_rd,
  output logic        ide_wr,
  output logic [15:0] ide_wdata,
  input  logic [15:0] ide_rdata
);
  localparam int WIN_LSB = 5;

  logic       phase;
  logic [7:0] hold;

  wire in_win  = bus_addr[9:WIN_LSB] == BASE[9:WIN_LSB];
  wire one_stb = bus_rd ^ bus_wr;
  wire rd_data = in_win & bus_rd & ~bus_wr & (bus_addr[4:0] == 5'h00);
  wire wr_data = in_win & bus_wr & ~bus_rd & (bus_addr[4:0] == 5'h10);
  wire reg_hit = in_win & one_stb & (bus_addr[4:3] == 2'b00) & (bus_addr[2:0] != 3'd0);

  assign ide_rd    = (rd_data & ~phase) | (reg_hit & bus_rd);
  assign ide_wr    = (wr_data & phase) | (reg_hit & bus_wr);
  assign ide_reg   = reg_hit ? bus_addr[2:0] : 3'd0;
  assign ide_wdata = reg_hit ? {8'h00, bus_wdata} : {bus_wdata, hold};
  assign bus_rdata = rd_data ? (phase ? hold : ide_rdata[7:0]) :
                     (reg_hit & bus_rd) ? ide_rdata[7:0] : 8'h00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= 1'b0;
      hold  <= 8'h00;
    end else if (reg_hit) begin
      phase <= 1'b0;
    end else if (rd_data | wr_data) begin
      phase <= ~phase;
      if (!phase) hold <= rd_data ? ide_rdata[15:8] : bus_wdata;
    end
  end

  p_strobes_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(ide_rd && ide_wr));
  p_drive_rd_needs_host_rd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ide_rd |-> (bus_rd && !bus_wr && in_win));
  p_read_captures_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && ide_rd) |=> (hold == $past(ide_rdata[15:8])));
  p_write_stores_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && !ide_wr) |=> (hold == $past(bus_wdata)));
  p_phase_toggles_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data || wr_data) |=> (phase != $past(phase)));
  p_reg_clears_phase_r8: assert property (@(posedge clk) disable iff (!rst_n)
    reg_hit |=> !phase);
  p_idle_keeps_state_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_data || wr_data || reg_hit) |=> ($stable(phase) && $stable(hold)));
endmodule

// File: tb/ide_byte_bridge_tb.sv
module ide_byte_bridge_tb;
  localparam logic [9:0] BASE = 10'h300;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  bus_addr = '0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [2:0]  ide_reg;
  logic        ide_rd, ide_wr;
  logic [15:0] ide_wdata;
  logic [15:0] ide_rdata = '0;

  int checks = 0, fails = 0;
  bit m_phase = 1'b0;
  logic [7:0] m_hold = 8'h00;

  always #10 clk = ~clk;

  ide_byte_bridge #(.BASE(BASE)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ide_reg(ide_reg), .ide_rd(ide_rd),
    .ide_wr(ide_wr), .ide_wdata(ide_wdata), .ide_rdata(ide_rdata));

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit f_win(logic [9:0] a);
    return a[9:5] == BASE[9:5];
  endfunction
  function automatic bit f_rdat(logic [9:0] a, bit r, bit w);
    return f_win(a) && r && !w && a[4:0] == 5'h00;
  endfunction
  function automatic bit f_wdat(logic [9:0] a, bit r, bit w);
    return f_win(a) && w && !r && a[4:0] == 5'h10;
  endfunction
  function automatic bit f_reg(logic [9:0] a, bit r, bit w);
    return f_win(a) && (r ^ w) && a[4:3] == 2'b00 && a[2:0] != 3'd0;
  endfunction

  task automatic access(string req, logic [9:0] a, bit r, bit w, logic [7:0] wd, logic [15:0] rd);
    bit er, ew, rh, wh, gh;
    logic [7:0] erd;
    logic [15:0] ewd;
    @(negedge clk);
    bus_addr = a; bus_rd = r; bus_wr = w; bus_wdata = wd; ide_rdata = rd;
    #2;
    rh = f_rdat(a, r, w); wh = f_wdat(a, r, w); gh = f_reg(a, r, w);
    er = (rh && !m_phase) || (gh && r);
    ew = (wh && m_phase) || (gh && w);
    erd = rh ? (m_phase ? m_hold : rd[7:0]) : (gh && r) ? rd[7:0] : 8'h00;
    ewd = gh ? {8'h00, wd} : {wd, m_hold};
    chk(req, "ide_rd", ide_rd, er);
    chk(req, "ide_wr", ide_wr, ew);
    chk(req, "bus_rdata", bus_rdata, erd);
    if (er || ew) chk(req, "ide_reg", ide_reg, gh ? a[2:0] : 3'd0);
    if (ew) chk(req, "ide_wdata", ide_wdata, ewd);
    @(posedge clk); #1;
    if (gh) m_phase = 1'b0;
    else if (rh || wh) begin
      if (!m_phase) m_hold = rh ? rd[15:8] : wd;
      m_phase = ~m_phase;
    end
    bus_rd = 1'b0; bus_wr = 1'b0;
  endtask

  initial begin
    fork
      begin #4000000; fails++; $display("FAIL watchdog: actual hung expected done"); end
      begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #2;
        chk("R1", "idle ide_rd", ide_rd, 0);
        chk("R1", "idle ide_wr", ide_wr, 0);
        chk("R1", "idle rdata", bus_rdata, 0);
        rst_n = 1'b1;
        // R3 R4: read pair
        access("R3", BASE, 1, 0, 8'h00, 16'hBEEF);
        access("R4", BASE, 1, 0, 8'h00, 16'h1234);
        // R5 R6: write pair
        access("R5", BASE + 10'h10, 0, 1, 8'h5A, 16'h0);
        access("R6", BASE + 10'h10, 0, 1, 8'hC3, 16'h0);
        // R7: wrong direction ignored, then first read still strobes
        access("R7", BASE, 0, 1, 8'h77, 16'h0);
        access("R7", BASE + 10'h10, 1, 0, 8'h00, 16'hAAAA);
        access("R7", BASE, 1, 0, 8'h00, 16'h9911);
        // R8: register access mid-pair restarts pairing
        access("R8", BASE + 10'h7, 1, 0, 8'h00, 16'h00F0);
        access("R8", BASE, 1, 0, 8'h00, 16'h4321);
        // R9: pass-through and dead offsets
        access("R9", BASE + 10'h3, 0, 1, 8'h42, 16'h0);
        access("R9", BASE + 10'h9, 1, 0, 8'h00, 16'h5555);
        // R2: out-of-window aliases
        access("R2", 10'h100, 1, 0, 8'h00, 16'h6666);
        access("R2", 10'h110, 0, 1, 8'h12, 16'h0);
        // R10: both strobes
        access("R10", BASE, 1, 1, 8'h34, 16'h7777);
        access("R10", BASE + 10'h10, 0, 1, 8'h01, 16'h0);
        access("R6", BASE + 10'h10, 0, 1, 8'h02, 16'h0);
        for (int i = 0; i < 600; i++) begin
          logic [9:0] a;
          int k = $urandom_range(0, 9);
          bit r, w;
          case (k)
            0, 1, 2: a = BASE;
            3, 4, 5: a = BASE + 10'h10;
            6:       a = BASE + 10'($urandom_range(1, 7));
            7:       a = BASE + 10'($urandom_range(0, 31));
            default: a = 10'($urandom);
          endcase
          r = (k % 2 == 0); w = !r;
          if (k <= 2) begin r = 1; w = 0; end
          else if (k <= 5) begin r = 0; w = 1; end
          if ($urandom_range(0, 19) == 0) begin r = 1; w = 1; end
          else if ($urandom_range(0, 19) == 0) begin r = ~r; w = ~w; end
          access("R8", a, r, w, 8'($urandom), 16'($urandom));
        end
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule